// File: doc/BRIEF.md
# SPI Master Frame Engine

This block is the serial core of an SPI master. It takes one word at a time from a ready/valid transmit port that stands in for a transmit queue. It sends the word most significant bit first on the data output and drives the serial clock and an active-low frame select. At the same time it shifts in the same number of bits from the data input. Each received word comes back on a one-cycle valid strobe. The word length can be set from 4 to 16 bits. Clock idle level (`cpol`) and sampling phase (`cpha`) are selected per transfer.

The serial clock comes from the system clock. Each serial half period lasts `DIV` system cycles. Polarity, phase and word length are taken when a transfer starts out of idle. They stay fixed until the engine is idle again. Back-to-back words are handled differently by phase. With `cpha=0`, frame select pulses high for one serial period between words. With `cpha=1`, the next word follows the previous one without a break in frame select or in the clock.

Top module: `spi_frame_master`

## Requirements
- R1: A word of N bits (N = `word_len`, 4 to 16; values outside this range saturate to it) is shifted out on `mosi` most significant bit first. N bits are sent per word.
- R2: While no transfer is active, `cs_n` is 1, `mosi` is 0 and `sclk` rests at `cpol` (0 for `cpol=0`, 1 for `cpol=1`).
- R3: A transfer starts only when `en` is 1 and `tx_valid` is 1. `tx_ready` is 0 whenever `en` is 0. `cs_n` falls in the cycle after a word is accepted (`tx_valid && tx_ready` at a clock edge).
- R4: With `cpha=0`, the first clock edge comes 2*DIV system cycles after `cs_n` falls. The first data bit appears DIV cycles after the fall, and data is captured on odd-numbered edges (first, third, ...).
- R5: With `cpha=1`, the first clock edge comes DIV cycles after `cs_n` falls. Data is launched on odd-numbered edges and captured on even-numbered edges.
- R6: `miso` is sampled on the capture edges given by R4/R5. The bits collected for a word equal the word the remote device sent, in all four polarity/phase combinations.
- R7: `cs_n` stays low for (K*2N + 2)*DIV system cycles, where K is the number of words in the frame (K=1 for a single word). It therefore returns high one serial period after the last capture.
- R8: With `cpha=0` and a word waiting, `cs_n` goes high between words for exactly 2*DIV+1 system cycles before falling again.
- R9: With `cpha=1` and a next word offered when the last bit of the current word is captured, that word is accepted in the same cycle. `cs_n` stays low and the clock continues without a pause.
- R10: `rx_valid` is high for exactly one cycle, the cycle after the last bit of a word is captured. `rx_data` then holds the word right-aligned, with its upper 16-N bits zero.
- R11: Changes to `cpol`, `cpha` or `word_len` during a transfer have no effect until the engine is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Allows new transfers to start |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on first edge; 1: capture on second edge |
| word_len | input | 5 | Bits per word, 4 to 16 |
| tx_data | input | 16 | Word to send, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine takes the offered word at this edge |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low frame select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_data | output | 16 | Last received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The critical coincidence happens with `cpha=1`. The capture of a word's final bit, the `rx_valid` strobe for that word and the acceptance and load of the next transmit word all fall on the same clock edge. The bench provokes this by keeping `tx_valid` high through multi-word runs in phase-1 modes. A simulated remote device checks the outcome. The old word must arrive intact on `rx_data` and the new word must come out bit-exact on `mosi`. `cs_n` must also stay low, with a low time equal to the sum of all chained words.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [1:0] {
    FE_IDLE = 2'd0,
    FE_XFER = 2'd1,
    FE_GAP  = 2'd2
  } fe_state_t;
endpackage

// File: rtl/spi_fe_tick.sv
module spi_fe_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
  parameter int MAXW = 16,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MAXW-1:0] load_data,
  input  logic [LW-1:0]   len,
  input  logic            launch,
  input  logic            capture,
  input  logic            miso,
  output logic            tx_msb,
  output logic [MAXW-1:0] rx_next
);
  logic [MAXW-1:0] tx_sh;
  logic [MAXW-1:0] rx_sh;

  assign tx_msb  = tx_sh[MAXW-1];
  assign rx_next = {rx_sh[MAXW-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load) begin
        tx_sh <= load_data << (LW'(MAXW) - len);
      end else if (launch) begin
        tx_sh <= tx_sh << 1;
      end
      if (load) begin
        rx_sh <= '0;
      end else if (capture) begin
        rx_sh <= rx_next;
      end
    end
  end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DIV  = 2,
  parameter int MAXW = 16,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cpol,
  input  logic            cpha,
  input  logic [LW-1:0]   word_len,
  input  logic [MAXW-1:0] tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic            sclk,
  output logic            cs_n,
  output logic            mosi,
  input  logic            miso,
  output logic [MAXW-1:0] rx_data,
  output logic            rx_valid
);
  import spi_fe_pkg::*;

  localparam int MINW = 4;
  localparam int HW   = $clog2(2 * MAXW + 3);

  fe_state_t       state;
  logic [HW-1:0]   h;
  logic [HW-1:0]   hn;
  logic [HW-1:0]   two_n;
  logic            cpol_l, cpha_l;
  logic [LW-1:0]   len_l, len_eff, len_load;
  logic            tick, start, last_cap, chain, load;
  logic            launch, capture, toggle;
  logic            tx_msb;
  logic [MAXW-1:0] rx_next;

  assign len_eff = (word_len < LW'(MINW)) ? LW'(MINW) :
                   (word_len > LW'(MAXW)) ? LW'(MAXW) : word_len;

  assign hn    = h + 1'b1;
  assign two_n = HW'(len_l) << 1;

  assign start    = (state == FE_IDLE) && en && tx_valid;
  assign last_cap = (state == FE_XFER) && tick && (hn == two_n);
  assign chain    = last_cap && cpha_l && en && tx_valid;
  assign load     = start || chain;
  assign len_load = start ? len_eff : len_l;
  assign tx_ready = en && ((state == FE_IDLE) || (last_cap && cpha_l));

  assign launch  = (state == FE_XFER) && tick && hn[0] && (hn < two_n);
  assign capture = (state == FE_XFER) && tick && !hn[0] &&
                   (hn >= HW'(2)) && (hn <= two_n);
  assign toggle  = (state == FE_XFER) && tick &&
                   (cpha_l ? (hn >= HW'(1) && hn <= two_n)
                           : (hn >= HW'(2) && hn <= two_n + HW'(1)));

  spi_fe_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != FE_IDLE),
    .tick (tick)
  );

  spi_fe_shift #(.MAXW(MAXW), .LW(LW)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (tx_data),
    .len       (len_load),
    .launch    (launch),
    .capture   (capture),
    .miso      (miso),
    .tx_msb    (tx_msb),
    .rx_next   (rx_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= FE_IDLE;
      h        <= '0;
      cpol_l   <= 1'b0;
      cpha_l   <= 1'b0;
      len_l    <= LW'(MINW);
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      mosi     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        FE_IDLE: begin
          sclk <= cpol;
          mosi <= 1'b0;
          cs_n <= 1'b1;
          if (start) begin
            state  <= FE_XFER;
            h      <= '0;
            cs_n   <= 1'b0;
            cpol_l <= cpol;
            cpha_l <= cpha;
            len_l  <= len_eff;
          end
        end
        FE_XFER: begin
          if (tick) begin
            h <= hn;
            if (toggle) sclk <= ~sclk;
            if (launch) mosi <= tx_msb;
            if (last_cap) begin
              rx_data  <= rx_next;
              rx_valid <= 1'b1;
              if (chain) h <= '0;
            end
            if (hn == two_n + HW'(2)) begin
              cs_n  <= 1'b1;
              mosi  <= 1'b0;
              state <= FE_GAP;
              h     <= '0;
            end
          end
        end
        FE_GAP: begin
          if (tick) begin
            h <= hn;
            if (hn == HW'(2)) state <= FE_IDLE;
          end
        end
        default: state <= FE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_frame_master_chk.sv
module spi_frame_master_chk #(
  parameter int DIV = 2
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tx_valid,
  input logic tx_ready,
  input logic cs_n,
  input logic mosi,
  input logic rx_valid
);
  logic [15:0] hi_cnt;
  logic        seen_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      seen_low <= 1'b0;
    end else begin
      if (!cs_n) begin
        hi_cnt   <= '0;
        seen_low <= 1'b1;
      end else if (hi_cnt != 16'hFFFF) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  assert_idle_mosi_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !mosi);

  assert_no_ready_R3: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tx_ready);

  assert_fall_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(tx_valid && tx_ready));

  assert_accept_low_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !cs_n);

  assert_gap_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(cs_n) && seen_low) |-> (hi_cnt >= 16'(2 * DIV)));

  assert_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind spi_frame_master spi_frame_master_chk #(.DIV(DIV)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .cs_n     (cs_n),
  .mosi     (mosi),
  .rx_valid (rx_valid)
);

// File: tb/spi_frame_master_bench.sv
module spi_frame_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;

  logic        clk = 0;
  logic        rst = 1;
  logic        en = 0, cpol = 0, cpha = 0;
  logic [4:0]  word_len = 5'd8;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 0;
  logic        tx_ready, sclk, cs_n, mosi;
  logic        miso = 0;
  logic [15:0] rx_data;
  logic        rx_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_master #(.DIV(DIV)) u_spi_frame_master (
    .clk(clk), .rst(rst), .en(en), .cpol(cpol), .cpha(cpha),
    .word_len(word_len), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [15:0] txw [0:1023];
  logic [15:0] sw  [0:1023];
  int send_idx = 0, mon_idx = 0, rx_idx = 0;
  int cur_n = 8;
  bit cur_cpol = 0, cur_cpha = 0;
  bit expect_gap = 0, had_frame = 0, mon_on = 0;
  int last_wif = 0;

  function automatic logic [15:0] mask_w(logic [15:0] w, int n);
    return w & 16'((32'd1 << n) - 1);
  endfunction

  function automatic int exp_lead(bit ph);
    return (ph ? DIV : 2 * DIV) + 1;
  endfunction

  function automatic int exp_low(int k, int n);
    return (k * 2 * n + 2) * DIV;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // remote device model and frame monitor
  bit prev_cs = 1, prev_sclk = 0, first_seen = 0, cap, last_cap_now;
  int low_cnt = 0, high_cnt = 0, edges = 0, wif = 0, bitp = 0;
  logic [15:0] mrx = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      last_cap_now = 0;
      if (!cs_n && prev_cs) begin
        if (had_frame && expect_gap)
          chk(high_cnt == 2 * DIV + 1, "R8 gap", high_cnt, 2 * DIV + 1);
        low_cnt = 0; edges = 0; wif = 0; first_seen = 0; mrx = '0;
        bitp = cur_n - 1;
        if (!cur_cpha) begin
          miso = sw[mon_idx][bitp];
          bitp--;
        end
      end
      if (!cs_n) begin
        low_cnt++;
        if (sclk != prev_sclk) begin
          edges++;
          if (!first_seen) begin
            first_seen = 1;
            chk(low_cnt == exp_lead(cur_cpha), cur_cpha ? "R5 lead" : "R4 lead",
                low_cnt, exp_lead(cur_cpha));
          end
          cap = cur_cpha ? (edges % 2 == 0) : (edges % 2 == 1);
          if (cap) begin
            mrx = {mrx[14:0], mosi};
            if (edges == (cur_cpha ? 2 * cur_n : 2 * cur_n - 1)) last_cap_now = 1;
          end else if (cur_cpha || edges < 2 * cur_n) begin
            miso = sw[mon_idx][bitp];
            bitp--;
          end
          if (edges == 2 * cur_n) begin
            chk(mrx == mask_w(txw[mon_idx], cur_n), "R1 mosi word",
                int'(mrx), int'(mask_w(txw[mon_idx], cur_n)));
            mon_idx++; wif++; edges = 0; mrx = '0; bitp = cur_n - 1;
          end
        end
      end
      if (cs_n && !prev_cs) begin
        chk(low_cnt == exp_low(wif, cur_n), "R7 low time", low_cnt, exp_low(wif, cur_n));
        chk(sclk == cur_cpol && !mosi, "R2 end levels", int'({sclk, mosi}), int'({cur_cpol, 1'b0}));
        last_wif = wif;
        high_cnt = 0;
        had_frame = 1;
      end
      if (cs_n) high_cnt++;
      if (rx_valid) begin
        chk(last_cap_now, "R10 strobe timing", int'(last_cap_now), 1);
        chk(rx_data == mask_w(sw[rx_idx], cur_n), "R6 rx word",
            int'(rx_data), int'(mask_w(sw[rx_idx], cur_n)));
        rx_idx++;
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  task automatic send(logic [15:0] w);
    tx_data = w;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (rx_idx < send_idx) @(negedge clk);
    repeat (4 * DIV + 4) @(negedge clk);
  endtask

  // k words; cont=1 keeps the next word offered
  task automatic run(bit pol, bit ph, int n, int k, bit cont);
    cur_cpol = pol; cur_cpha = ph; cur_n = n;
    cpol = pol; cpha = ph; word_len = 5'(n);
    expect_gap = cont && !ph;
    had_frame = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      txw[send_idx] = 16'($urandom);
      sw[send_idx]  = 16'($urandom);
      send_idx++;
      send(txw[send_idx - 1]);
      if (!cont) begin
        tx_valid = 0;
        wait_idle();
      end
    end
    tx_valid = 0;
    wait_idle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    mon_on = 1;
    @(negedge clk);
    chk(cs_n && !mosi && sclk == 1'b0, "R2 reset idle", int'({cs_n, mosi, sclk}), 4);
    cpol = 1;
    repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R2 idle follows cpol", int'(sclk), 1);

    // disabled engine must not start
    en = 0; tx_data = 16'hA5A5; tx_valid = 1;
    @(negedge clk);
    chk(!tx_ready, "R3 ready low when disabled", int'(tx_ready), 0);
    repeat (20) @(negedge clk);
    chk(cs_n, "R3 no start when disabled", int'(cs_n), 1);
    tx_valid = 0; en = 1;

    // directed corners: every mode at both length limits
    for (int m = 0; m < 4; m++) begin
      run(m[1], m[0], 4, 1, 0);
      run(m[1], m[0], 16, 1, 0);
    end

    // SPH=0 continuous: frame select pulses between words
    run(0, 0, 8, 3, 1);
    run(1, 0, 11, 3, 1);

    // SPH=1 continuous: words chained under one low frame select
    run(0, 1, 9, 4, 1);
    chk(last_wif == 4, "R9 chained words", last_wif, 4);
    run(1, 1, 16, 3, 1);
    chk(last_wif == 3, "R9 chained words", last_wif, 3);

    // configuration change during a transfer
    cur_cpol = 0; cur_cpha = 0; cur_n = 12;
    cpol = 0; cpha = 0; word_len = 5'd12; had_frame = 0; expect_gap = 0;
    repeat (3) @(negedge clk);
    txw[send_idx] = 16'h9C3B; sw[send_idx] = 16'h5E71; send_idx++;
    send(16'h9C3B);
    tx_valid = 0;
    repeat (10) @(negedge clk);
    cpol = 1; cpha = 1; word_len = 5'd5;
    wait_idle();
    chk(rx_idx == send_idx, "R11 frame kept settings", rx_idx, send_idx);
    chk(sclk == 1'b1, "R11 new polarity after idle", int'(sclk), 1);
    cur_cpol = 1;

    // random mix
    for (int i = 0; i < 30; i++) begin
      int r = int'($urandom);
      run(r[0], r[1], 4 + int'($urandom % 13), 1 + int'($urandom % 3), r[2]);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule